// File: doc/BRIEF.md
# Operand Forwarding and Interlock Unit

This unit sits beside the operand-collection stage of an in-order pipeline with five stages: fetch, decode, operand read, execute and write-back. Each cycle it compares the two source register numbers of the instruction being read against the destinations of the two older instructions still in flight. For each source it either picks the register-file value, picks a result being forwarded from a later stage, or holds the front of the pipeline for a cycle.

The unit tracks which older instructions write which registers. It keeps the destination number and write flag of the instruction in execute and of the one in write-back, and it advances them itself. The data values come from outside: the register-file read ports, the ALU output of the instruction in execute, and the value being written back this cycle. The register file does not pass a same-cycle write through to its read ports, so a write is seen by a read only in a later cycle.

Two elaboration parameters select the variant. `FWD_EN` turns the bypass paths on or off. `MERGED` models a pipeline in which decode and operand read are one stage. In that case the operand mux sits behind the ALU output, so an ALU result can feed the very next instruction.

Top module: `opfwd_unit`

## Requirements
- R1: A source with no matching in-flight producer gets source code 0 (register file) and the matching register-file data, and does not stall.
- R2: Register 0 never matches. A slot whose write flag is low never matches. A source whose use flag is low never matches.
- R3: When both the execute slot and the write-back slot write the same source register, only the execute (younger) slot is considered.
- R4: With forwarding on, a source that matches only the write-back slot gets source code 1 and the write-back result in that same cycle, with no stall.
- R5: With forwarding on and stages split, a source matching the execute slot raises stall for exactly one cycle. The producer is then forwarded from write-back.
- R6: In a stall cycle, and in a cycle with the valid input low, nothing is entered into the execute slot (a bubble). A held instruction that writes its own source therefore does not block itself.
- R7: With forwarding off, a matching source stalls until its producer has left write-back. This costs two cycles at distance one and one cycle at distance two, in both stage arrangements.
- R8: With forwarding on and stages merged, a source matching the execute slot gets source code 2 and the ALU output, and the unit never stalls.
- R9: The two sources are resolved independently, each with its own source code and data.
- R10: Stall is never raised while the valid input is low. After reset both in-flight slots are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | An instruction is present in operand read |
| src_idx_a | input | IDX_W | First source register number |
| src_use_a | input | 1 | First source is read |
| src_idx_b | input | IDX_W | Second source register number |
| src_use_b | input | 1 | Second source is read |
| dst_idx | input | IDX_W | Destination register of the instruction in operand read |
| dst_wr | input | 1 | That instruction writes its destination |
| rf_data_a | input | DATA_W | Register-file read data for the first source |
| rf_data_b | input | DATA_W | Register-file read data for the second source |
| alu_result | input | DATA_W | ALU output of the instruction in execute |
| wb_result | input | DATA_W | Value being written back this cycle |
| pick_a | output | 2 | First source origin: 0 register file, 1 write-back, 2 execute |
| pick_b | output | 2 | Second source origin, same coding |
| opnd_a | output | DATA_W | First operand value |
| opnd_b | output | DATA_W | Second operand value |
| stall | output | 1 | Hold fetch, decode and operand read; bubble into execute |

## Verification
The assertions assume only two things about the inputs. Reset is held low for at least two clock edges. The data inputs are stable while the operand outputs are sampled. They make no assumption about register numbers or flag patterns, so they must hold under any instruction sequence. The stimulus holds reset for three edges. It changes inputs only on the falling edge and holds an instruction unchanged for as long as stall is high, as a real front end would. Four copies of the unit, one for each forwarding and stage arrangement, receive the same stimulus. The number of stalled cycles each copy takes per dependent instruction is compared with the expected penalty for that arrangement.

// File: rtl/opfwd_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the operand forwarding unit.
// Assumes nothing beyond the 2-bit operand-origin coding below.
package opfwd_pkg;
    typedef enum logic [1:0] {
        ORIG_RF   = 2'd0,
        ORIG_WB   = 2'd1,
        ORIG_EXEC = 2'd2
    } opnd_orig_e;
endpackage

// File: rtl/opfwd_slot_track.sv
`timescale 1ns/1ps
// Tracks the destination register and write flag of the instructions in
// execute and write-back. Advances every cycle; on a hold (advance low) or an
// invalid operand-read slot a bubble enters execute.
// Assumes: synchronous active-low reset held for at least two edges.
module opfwd_slot_track #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             in_valid,
    input  logic             in_wr,
    input  logic [IDX_W-1:0] in_idx,
    output logic             ex_wr,
    output logic [IDX_W-1:0] ex_idx,
    output logic             wb_wr,
    output logic [IDX_W-1:0] wb_idx
);
    // Shift the destination tags one stage per cycle, bubbling execute on hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_wr  <= 1'b0;
            ex_idx <= '0;
            wb_wr  <= 1'b0;
            wb_idx <= '0;
        end else begin
            ex_wr  <= advance && in_valid && in_wr;
            ex_idx <= in_idx;
            wb_wr  <= ex_wr;
            wb_idx <= ex_idx;
        end
    end

    // R6: a held slot never reaches execute
    p_hold_bubbles_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> !ex_wr);

    // R6: an invalid operand-read slot never reaches execute
    p_invalid_bubbles_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !ex_wr);

    // R3: write-back always holds what execute held one cycle earlier
    p_wb_follows_ex_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wb_wr == $past(ex_wr)) && (wb_idx == $past(ex_idx)));
endmodule

// File: rtl/opfwd_operand_pick.sv
`timescale 1ns/1ps
// Resolves one source operand against the execute and write-back slots.
// The younger (execute) slot is checked first. Register 0 never matches.
// A match that cannot be bypassed in this variant requests a hold.
// Assumes: the register file does not pass same-cycle writes to its reads.
module opfwd_operand_pick
    import opfwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    parameter bit FWD_EN = 1'b1,
    parameter bit MERGED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic              src_use,
    input  logic              ex_wr,
    input  logic [IDX_W-1:0]  ex_idx,
    input  logic              wb_wr,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] rf_data,
    input  logic [DATA_W-1:0] alu_data,
    input  logic [DATA_W-1:0] wb_data,
    output opnd_orig_e        orig,
    output logic [DATA_W-1:0] data,
    output logic              need_hold
);
    localparam bit EX_BYPASS = FWD_EN && MERGED;
    localparam bit WB_BYPASS = FWD_EN;

    logic live;
    logic hit_ex;
    logic hit_wb;

    // Compare the source against each in-flight destination.
    always_comb begin
        live   = src_use && (src_idx != '0);
        hit_ex = live && ex_wr && (ex_idx == src_idx);
        hit_wb = live && wb_wr && (wb_idx == src_idx);
    end

    // Choose the operand origin with the execute slot taking priority.
    always_comb begin
        orig      = ORIG_RF;
        data      = rf_data;
        need_hold = 1'b0;
        if (hit_ex) begin
            if (EX_BYPASS) begin
                orig = ORIG_EXEC;
                data = alu_data;
            end else begin
                need_hold = 1'b1;
            end
        end else if (hit_wb) begin
            if (WB_BYPASS) begin
                orig = ORIG_WB;
                data = wb_data;
            end else begin
                need_hold = 1'b1;
            end
        end
    end

    // R2: register 0 is always taken from the register file
    p_zero_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_idx == '0) |-> (orig == ORIG_RF) && !need_hold);

    // R2: an unused source never holds or bypasses
    p_unused_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !src_use |-> (orig == ORIG_RF) && !need_hold);

    // R4: a write-back origin carries the write-back value
    p_wb_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (orig == ORIG_WB) |-> (data == wb_data));

    generate
        if (!EX_BYPASS) begin : g_no_ex_path
            // R5: without the execute path the execute origin never appears
            p_no_exec_orig_r5: assert property (@(posedge clk) disable iff (!rst_n)
                orig != ORIG_EXEC);
        end
        if (!FWD_EN) begin : g_no_bypass
            // R7: with forwarding off only the register file is used
            p_rf_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
                orig == ORIG_RF);
        end
    endgenerate
endmodule

// File: rtl/opfwd_unit.sv
`timescale 1ns/1ps
// Operand forwarding and interlock unit for a five-stage in-order pipeline.
// Resolves both sources of the instruction in operand read against the two
// older in-flight instructions. It bypasses where the variant allows and
// otherwise raises stall, which also bubbles execute.
// Assumes: the front end holds its instruction unchanged while stall is high.
module opfwd_unit
    import opfwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_N  = 32,
    parameter bit FWD_EN = 1'b1,
    parameter bit MERGED = 1'b0,
    localparam int IDX_W = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [IDX_W-1:0]  src_idx_a,
    input  logic              src_use_a,
    input  logic [IDX_W-1:0]  src_idx_b,
    input  logic              src_use_b,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic              dst_wr,
    input  logic [DATA_W-1:0] rf_data_a,
    input  logic [DATA_W-1:0] rf_data_b,
    input  logic [DATA_W-1:0] alu_result,
    input  logic [DATA_W-1:0] wb_result,
    output logic [1:0]        pick_a,
    output logic [1:0]        pick_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b,
    output logic              stall
);
    localparam int N_SRC = 2;

    logic             ex_wr;
    logic [IDX_W-1:0] ex_idx;
    logic             wb_wr;
    logic [IDX_W-1:0] wb_idx;

    logic [IDX_W-1:0]  s_idx  [N_SRC];
    logic              s_use  [N_SRC];
    logic [DATA_W-1:0] s_rf   [N_SRC];
    opnd_orig_e        s_orig [N_SRC];
    logic [DATA_W-1:0] s_data [N_SRC];
    logic [N_SRC-1:0]  s_hold;

    // Gather the per-source inputs into arrays.
    always_comb begin
        s_idx[0] = src_idx_a;
        s_idx[1] = src_idx_b;
        s_use[0] = src_use_a;
        s_use[1] = src_use_b;
        s_rf[0]  = rf_data_a;
        s_rf[1]  = rf_data_b;
    end

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            opfwd_operand_pick #(
                .DATA_W (DATA_W),
                .IDX_W  (IDX_W),
                .FWD_EN (FWD_EN),
                .MERGED (MERGED)
            ) i_pick (
                .clk       (clk),
                .rst_n     (rst_n),
                .src_idx   (s_idx[i]),
                .src_use   (s_use[i]),
                .ex_wr     (ex_wr),
                .ex_idx    (ex_idx),
                .wb_wr     (wb_wr),
                .wb_idx    (wb_idx),
                .rf_data   (s_rf[i]),
                .alu_data  (alu_result),
                .wb_data   (wb_result),
                .orig      (s_orig[i]),
                .data      (s_data[i]),
                .need_hold (s_hold[i])
            );
        end
    endgenerate

    // Hold the front end when any live source cannot be bypassed.
    always_comb begin
        stall  = rd_valid && (|s_hold);
        pick_a = s_orig[0];
        pick_b = s_orig[1];
        opnd_a = s_data[0];
        opnd_b = s_data[1];
    end

    opfwd_slot_track #(
        .IDX_W (IDX_W)
    ) i_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (!stall),
        .in_valid (rd_valid),
        .in_wr    (dst_wr),
        .in_idx   (dst_idx),
        .ex_wr    (ex_wr),
        .ex_idx   (ex_idx),
        .wb_wr    (wb_wr),
        .wb_idx   (wb_idx)
    );

    // R10: no stall without an instruction in operand read
    p_idle_no_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> !stall);

    generate
        if (FWD_EN && !MERGED) begin : g_split_fwd
            // R5: an interlock lasts exactly one cycle when bypassing from write-back
            p_single_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
                stall |=> !stall);
        end
        if (FWD_EN && MERGED) begin : g_merged_fwd
            // R8: merged stages with forwarding never interlock
            p_never_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !stall);
        end
        if (!FWD_EN) begin : g_no_fwd
            // R7: without forwarding a stall never exceeds two cycles
            p_hold_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
                stall && $past(stall) |=> !stall);
        end
    endgenerate
endmodule

// File: tb/test_opfwd_unit.sv
`timescale 1ns/1ps
// Directed bench: four variants (k0 split+fwd, k1 split no-fwd,
// k2 merged+fwd, k3 merged no-fwd) share one stimulus stream.
module test_opfwd_unit;
    localparam int DW = 32;
    localparam int IW = 5;
    localparam logic [DW-1:0] RFA = 32'h1111_0000;
    localparam logic [DW-1:0] RFB = 32'h2222_0000;
    localparam logic [DW-1:0] ALU = 32'hAAAA_0001;
    localparam logic [DW-1:0] WBV = 32'h5555_0002;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_valid = 1'b0;
    logic [IW-1:0] src_idx_a = '0, src_idx_b = '0, dst_idx = '0;
    logic src_use_a = 1'b0, src_use_b = 1'b0, dst_wr = 1'b0;

    logic [1:0]    pick_a_v [4];
    logic [1:0]    pick_b_v [4];
    logic [DW-1:0] opnd_a_v [4];
    logic [DW-1:0] opnd_b_v [4];
    logic          stall_v  [4];

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    generate
        for (genvar k = 0; k < 4; k++) begin : g_cfg
            opfwd_unit #(
                .DATA_W (DW),
                .REG_N  (32),
                .FWD_EN ((k % 2) == 0),
                .MERGED ((k / 2) == 1)
            ) i_opfwd_unit (
                .clk        (clk),
                .rst_n      (rst_n),
                .rd_valid   (rd_valid),
                .src_idx_a  (src_idx_a),
                .src_use_a  (src_use_a),
                .src_idx_b  (src_idx_b),
                .src_use_b  (src_use_b),
                .dst_idx    (dst_idx),
                .dst_wr     (dst_wr),
                .rf_data_a  (RFA),
                .rf_data_b  (RFB),
                .alu_result (ALU),
                .wb_result  (WBV),
                .pick_a     (pick_a_v[k]),
                .pick_b     (pick_b_v[k]),
                .opnd_a     (opnd_a_v[k]),
                .opnd_b     (opnd_b_v[k]),
                .stall      (stall_v[k])
            );
        end
    endgenerate

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rd_valid = 1'b0;
        dst_wr = 1'b0;
        src_use_a = 1'b0;
        src_use_b = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one instruction and count stalled cycles for variant k.
    task automatic issue(input int k, input int ra, input bit ua, input int rb, input bit ub,
                         input int rd, input bit wr, output int n);
        @(negedge clk);
        rd_valid  = 1'b1;
        src_idx_a = IW'(ra);
        src_use_a = ua;
        src_idx_b = IW'(rb);
        src_use_b = ub;
        dst_idx   = IW'(rd);
        dst_wr    = wr;
        n = 0;
        #5;
        while (stall_v[k] && n < 20) begin
            n++;
            @(negedge clk);
            #5;
        end
    endtask

    task automatic t_reset_state();
        int n;
        do_reset();
        for (int k = 0; k < 4; k++) begin
            do_reset();
            issue(k, 3, 1, 4, 1, 9, 1, n);
            chk(n == 0, "R10", "stall right after reset", n, 0);
            chk(pick_a_v[k] == 2'd0 && opnd_a_v[k] == RFA, "R1", "origin a after reset",
                opnd_a_v[k], RFA);
        end
    endtask

    // Back-to-back dependency on R3 for each variant.
    task automatic t_distance_one();
        int n;
        int exp_n [4] = '{1, 2, 0, 2};
        for (int k = 0; k < 4; k++) begin
            do_reset();
            issue(k, 0, 0, 0, 0, 3, 1, n);
            issue(k, 3, 1, 0, 0, 4, 1, n);
            chk(n == exp_n[k], (k == 0) ? "R5" : (k == 2) ? "R8" : "R7",
                "distance-1 stall count", n, exp_n[k]);
            if (k == 0) chk(pick_a_v[k] == 2'd1 && opnd_a_v[k] == WBV, "R4",
                            "bypass from write-back", opnd_a_v[k], WBV);
            if (k == 2) chk(pick_a_v[k] == 2'd2 && opnd_a_v[k] == ALU, "R8",
                            "bypass from execute", opnd_a_v[k], ALU);
            if (k == 1) chk(pick_a_v[k] == 2'd0 && opnd_a_v[k] == RFA, "R7",
                            "register file after stall", opnd_a_v[k], RFA);
        end
    endtask

    task automatic t_distance_two();
        int n;
        int exp_n [4] = '{0, 1, 0, 1};
        for (int k = 0; k < 4; k++) begin
            do_reset();
            issue(k, 0, 0, 0, 0, 3, 1, n);
            issue(k, 0, 0, 0, 0, 8, 1, n);
            issue(k, 0, 0, 3, 1, 4, 1, n);
            chk(n == exp_n[k], (k % 2 == 0) ? "R4" : "R7", "distance-2 stall count",
                n, exp_n[k]);
            if (k % 2 == 0) chk(pick_b_v[k] == 2'd1 && opnd_b_v[k] == WBV, "R4",
                                "distance-2 write-back bypass", opnd_b_v[k], WBV);
        end
    endtask

    // R3 = R3 op: the held instruction must not block on itself.
    task automatic t_self_dependent();
        int n;
        int exp_n [4] = '{1, 2, 0, 2};
        for (int k = 0; k < 4; k++) begin
            do_reset();
            issue(k, 0, 0, 0, 0, 3, 1, n);
            issue(k, 3, 1, 0, 0, 3, 1, n);
            chk(n == exp_n[k], "R6", "self-writing consumer stall count", n, exp_n[k]);
        end
    endtask

    task automatic t_priority();
        int n;
        do_reset();
        issue(2, 0, 0, 0, 0, 5, 1, n);
        issue(2, 0, 0, 0, 0, 5, 1, n);
        issue(2, 5, 1, 0, 0, 6, 1, n);
        chk(pick_a_v[2] == 2'd2 && opnd_a_v[2] == ALU, "R3", "younger execute slot wins",
            opnd_a_v[2], ALU);
        do_reset();
        issue(0, 0, 0, 0, 0, 5, 1, n);
        issue(0, 0, 0, 0, 0, 5, 1, n);
        issue(0, 5, 1, 0, 0, 6, 1, n);
        chk(n == 1, "R3", "execute match interlocks despite write-back match", n, 1);
    endtask

    task automatic t_no_match_cases();
        int n;
        do_reset();
        issue(1, 0, 0, 0, 0, 0, 1, n);
        issue(1, 0, 1, 0, 1, 7, 1, n);
        chk(n == 0 && pick_a_v[1] == 2'd0, "R2", "register 0 never matches", n, 0);
        do_reset();
        issue(1, 0, 0, 0, 0, 4, 0, n);
        issue(1, 4, 1, 0, 0, 7, 1, n);
        chk(n == 0, "R2", "write flag low never matches", n, 0);
        do_reset();
        issue(1, 0, 0, 0, 0, 6, 1, n);
        issue(1, 6, 0, 6, 0, 7, 1, n);
        chk(n == 0, "R2", "unused source never matches", n, 0);
        do_reset();
        issue(0, 0, 0, 0, 0, 6, 1, n);
        issue(0, 11, 1, 12, 1, 7, 1, n);
        chk(n == 0 && opnd_b_v[0] == RFB, "R1", "unrelated sources read file", opnd_b_v[0], RFB);
    endtask

    task automatic t_independent();
        int n;
        do_reset();
        issue(2, 0, 0, 0, 0, 7, 1, n);
        issue(2, 0, 0, 0, 0, 8, 1, n);
        issue(2, 7, 1, 8, 1, 9, 1, n);
        chk(opnd_a_v[2] == WBV && pick_a_v[2] == 2'd1, "R9", "source a from write-back",
            opnd_a_v[2], WBV);
        chk(opnd_b_v[2] == ALU && pick_b_v[2] == 2'd2, "R9", "source b from execute",
            opnd_b_v[2], ALU);
        do_reset();
        issue(0, 0, 0, 0, 0, 7, 1, n);
        issue(0, 0, 0, 0, 0, 8, 1, n);
        issue(0, 7, 1, 8, 1, 9, 1, n);
        chk(n == 1, "R9", "split variant interlocks on source b", n, 1);
        chk(pick_a_v[0] == 2'd0 && opnd_a_v[0] == RFA, "R9", "source a back to file",
            opnd_a_v[0], RFA);
        chk(pick_b_v[0] == 2'd1 && opnd_b_v[0] == WBV, "R9", "source b from write-back",
            opnd_b_v[0], WBV);
    endtask

    task automatic t_invalid_slot();
        int n;
        do_reset();
        issue(1, 0, 0, 0, 0, 3, 1, n);
        @(negedge clk);
        rd_valid  = 1'b0;
        src_idx_a = 5'd3;
        src_use_a = 1'b1;
        dst_idx   = 5'd9;
        dst_wr    = 1'b1;
        #5;
        chk(stall_v[1] == 1'b0, "R10", "no stall with valid low", stall_v[1], 0);
        issue(1, 0, 0, 0, 0, 10, 1, n);
        issue(1, 9, 1, 0, 0, 11, 1, n);
        chk(n == 0, "R6", "invalid slot left no producer", n, 0);
    endtask

    initial begin : main
        t_reset_state();
        t_distance_one();
        t_distance_two();
        t_self_dependent();
        t_priority();
        t_no_match_cases();
        t_independent();
        t_invalid_slot();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule